// File: doc/BRIEF.md
# Instruction-Count Preemption Scheduler

This block decides when a statically scheduled task set is preempted by counting retired instructions rather than clock ticks. Each task switch or planned data move therefore lands at the same program point in every scheduling round, whatever the cache or memory timing was. The CPU pulses a strobe for every instruction it retires. The block keeps a running count and compares it with a small table of planned points, which was loaded while the scheduler was stopped. At a point of the preempt kind it raises a one-cycle interrupt pulse that carries the table index and task ID. At a point of the transfer kind it raises a one-cycle trigger pulse that carries a transfer ID.

The schedule is cyclic. A global-time synchronization pulse re-anchors the count to zero at the start of each round, so the instruction-count clock stays tied to global time. After the last planned point of a round, the block waits idle for the next sync pulse. The round is planned to end with a window of inactivity, and the sync pulse may land anywhere in it; a pulse that arrives early still restarts the round cleanly. If the count passes an entry without an exact match, the table was inconsistent, and a sticky flag reports it.

Top module: `icount_preempt_sched`

## Requirements
- R1: After reset all pulse outputs, ID and index outputs and the overrun flag are 0, and every table entry reads as an end marker, so an unloaded table never produces a pulse.
- R2: While enabled, the count advances by one for each clock cycle in which retire_i is high. An entry whose action code is 0 (preempt) produces irq_o with irq_idx_o = entry index and irq_id_o = entry ID. The pulse is high in the cycle after the edge that follows the edge at which the count became equal to the entry's count.
- R3: An entry whose action code is 1 (transfer) produces xfer_o with xfer_id_o = entry ID, with the same timing as R2, and does not produce irq_o.
- R4: Each matched entry produces exactly one pulse, one cycle long.
- R5: Entries are visited strictly in table order, advancing one step per match. An entry whose action code has bit 1 set (codes 2 or 3) is an end marker: no later entry fires until the next sync pulse.
- R6: A sync pulse while enabled zeroes the count and the table pointer at the same edge. A retire strobe in the same cycle is not counted, and no entry fires at that edge.
- R7: When the count exceeds the current entry's count, the entry is skipped without a pulse and overrun_o is set. It stays set until reset.
- R8: A table write (tbl_we_i high, entry tbl_addr_i receives count tbl_cnt_i, action tbl_act_i, ID tbl_id_i) takes effect only while enable_i is low. A write while enabled leaves the table unchanged.
- R9: While enable_i is low, the count and pointer are held at zero, no pulse is produced, and sync pulses have no effect. When enable_i rises, counting starts from zero at the first enabled edge.
- R10: After the entry at the last table index has fired, the block stays idle until a sync pulse. The sync pulse then restarts the round from index 0.
- R11: A sync pulse is accepted at any time, whether the block is idle at the end of a round or still inside it. Either way, the next round repeats the same pulse pattern from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Scheduler run control; low stops counting and opens the table for writing |
| retire_i | input | 1 | One instruction retired this cycle |
| sync_i | input | 1 | Global-time synchronization pulse, starts a round |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 4 | Table entry written |
| tbl_cnt_i | input | 32 | Instruction count of the written entry |
| tbl_act_i | input | 2 | Action code: 0 preempt, 1 transfer, 2 or 3 end marker |
| tbl_id_i | input | 4 | Task or transfer ID of the written entry |
| irq_o | output | 1 | Preemption interrupt pulse |
| irq_idx_o | output | 4 | Table index of the entry that raised irq_o |
| irq_id_o | output | 4 | Task ID carried with irq_o |
| xfer_o | output | 1 | Data-transfer trigger pulse |
| xfer_id_o | output | 4 | Transfer ID carried with xfer_o |
| overrun_o | output | 1 | Sticky flag: an entry was passed without a match |

## Verification
Each result has a fixed latency. With retire held high and a sync pulse sampled at edge s, an entry of count K pulses in the cycle after edge s+K+1. When counting resumes on enable at edge e, the pulse comes in the cycle after edge e+K. An overrun shows one cycle after the count first exceeds the stuck entry's count. A retire strobe in the sync cycle would shift every later pulse one cycle early. The stimulus driver computes each pulse's due cycle from these rules and queues it. The monitor samples on the falling clock edge and compares the cycle number, pulse kind, index and ID against the queue head. A missed pulse is caught by a queue that has not drained, and an unexpected or doubled pulse by a pop from an empty queue or a mismatch.

// File: rtl/icps_pkg.sv
package icps_pkg;

  typedef enum logic [1:0] {
    ACT_PREEMPT = 2'd0,
    ACT_XFER    = 2'd1,
    ACT_END     = 2'd2,
    ACT_END_ALT = 2'd3
  } act_e;

  function automatic logic is_marker(act_e a);
    return a[1];
  endfunction

endpackage

// File: rtl/icps_table.sv
module icps_table
  import icps_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [CNT_W-1:0] wcnt_i,
  input  act_e             wact_i,
  input  logic [ID_W-1:0]  wid_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [CNT_W-1:0] rcnt_o,
  output act_e             ract_o,
  output logic [ID_W-1:0]  rid_o
);

  logic [CNT_W-1:0] cnt_q [N_ENTRIES];
  act_e             act_q [N_ENTRIES];
  logic [ID_W-1:0]  id_q  [N_ENTRIES];
  logic             wr_ok;

  // table is writable only while the scheduler is stopped
  assign wr_ok = we_i && !enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_ENTRIES); i++) begin
        cnt_q[i] <= '0;
        act_q[i] <= ACT_END;
        id_q[i]  <= '0;
      end
    end else if (wr_ok) begin
      for (int i = 0; i < int'(N_ENTRIES); i++) begin
        if (waddr_i == IDX_W'(i)) begin
          cnt_q[i] <= wcnt_i;
          act_q[i] <= wact_i;
          id_q[i]  <= wid_i;
        end
      end
    end
  end

  assign rcnt_o = cnt_q[raddr_i];
  assign ract_o = act_q[raddr_i];
  assign rid_o  = id_q[raddr_i];

  for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_chk
    p_locked_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enable_i |=> ($stable(cnt_q[g]) && $stable(act_q[g]) && $stable(id_q[g])));
  end

endmodule

// File: rtl/icps_counter.sv
module icps_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             sync_i,
  input  logic             retire_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!enable_i || sync_i)         cnt_q <= '0;   // sync wins over retire
    else if (retire_i && (cnt_q != '1))   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  p_sync_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sync_i) |=> (cnt_o == '0));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !sync_i && retire_i && (cnt_o != '1)) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !sync_i && !retire_i) |=> $stable(cnt_o));

  p_off_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (cnt_o == '0));

endmodule

// File: rtl/icps_matcher.sv
module icps_matcher
  import icps_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ent_cnt_i,
  input  act_e             ent_act_i,
  input  logic [ID_W-1:0]  ent_id_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic             xfer_o,
  output logic [ID_W-1:0]  xfer_id_o,
  output logic             overrun_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, irq_idx_q;
  logic [ID_W-1:0]  irq_id_q, xfer_id_q;
  logic             done_q, irq_q, xfer_q, ovr_q;
  logic             live, hit, miss, hit_irq, hit_xfer;

  assign live     = enable_i && !sync_i && !done_q && !is_marker(ent_act_i);
  assign hit      = live && (cnt_i == ent_cnt_i);
  assign miss     = live && (cnt_i >  ent_cnt_i);
  assign hit_irq  = hit && (ent_act_i == ACT_PREEMPT);
  assign hit_xfer = hit && (ent_act_i == ACT_XFER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      done_q    <= 1'b0;
      irq_q     <= 1'b0;
      xfer_q    <= 1'b0;
      irq_idx_q <= '0;
      irq_id_q  <= '0;
      xfer_id_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      irq_q     <= hit_irq;
      xfer_q    <= hit_xfer;
      irq_idx_q <= hit_irq  ? ptr_q    : '0;
      irq_id_q  <= hit_irq  ? ent_id_i : '0;
      xfer_id_q <= hit_xfer ? ent_id_i : '0;
      if (miss) ovr_q <= 1'b1;
      if (!enable_i || sync_i) begin
        ptr_q  <= '0;
        done_q <= 1'b0;
      end else if (hit || miss) begin
        if (ptr_q == LAST) done_q <= 1'b1;
        else               ptr_q  <= ptr_q + IDX_W'(1);
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign irq_o     = irq_q;
  assign irq_idx_o = irq_idx_q;
  assign irq_id_o  = irq_id_q;
  assign xfer_o    = xfer_q;
  assign xfer_id_o = xfer_id_q;
  assign overrun_o = ovr_q;

  p_single_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> (!irq_q || (irq_idx_q != $past(irq_idx_q))));

  p_no_back_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !sync_i) |=> (ptr_q >= $past(ptr_q)));

  p_sync_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sync_i) |=> ((ptr_q == '0) && !irq_q && !xfer_q));

  p_overrun_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);

  p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!irq_q && !xfer_q && (ptr_q == '0)));

  p_parked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !sync_i && done_q) |=> (!irq_q && !xfer_q && $stable(ptr_q)));

endmodule

// File: rtl/icount_preempt_sched.sv
module icount_preempt_sched
  import icps_pkg::*;
#(
  parameter  int unsigned N_ENTRIES = 16,
  parameter  int unsigned CNT_W     = 32,
  parameter  int unsigned ID_W      = 4,
  localparam int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             retire_i,
  input  logic             sync_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_addr_i,
  input  logic [CNT_W-1:0] tbl_cnt_i,
  input  logic [1:0]       tbl_act_i,
  input  logic [ID_W-1:0]  tbl_id_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic             xfer_o,
  output logic [ID_W-1:0]  xfer_id_o,
  output logic             overrun_o
);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] ent_cnt;
  act_e             ent_act;
  logic [ID_W-1:0]  ent_id;

  icps_table #(
    .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wcnt_i  (tbl_cnt_i),
    .wact_i  (act_e'(tbl_act_i)),
    .wid_i   (tbl_id_i),
    .raddr_i (ptr),
    .rcnt_o  (ent_cnt),
    .ract_o  (ent_act),
    .rid_o   (ent_id)
  );

  icps_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .sync_i  (sync_i),
    .retire_i(retire_i),
    .cnt_o   (cnt)
  );

  icps_matcher #(
    .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_matcher (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .sync_i   (sync_i),
    .cnt_i    (cnt),
    .ent_cnt_i(ent_cnt),
    .ent_act_i(ent_act),
    .ent_id_i (ent_id),
    .ptr_o    (ptr),
    .irq_o    (irq_o),
    .irq_idx_o(irq_idx_o),
    .irq_id_o (irq_id_o),
    .xfer_o   (xfer_o),
    .xfer_id_o(xfer_id_o),
    .overrun_o(overrun_o)
  );

endmodule

// File: tb/tb_icount_preempt_sched.sv
module tb_icount_preempt_sched;

  typedef struct {
    int    cyc;
    bit    xfer;
    int    idx;
    int    id;
    string req;
  } ev_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, retire_i = 1'b0, sync_i = 1'b0, tbl_we_i = 1'b0;
  logic [3:0]  tbl_addr_i = '0;
  logic [31:0] tbl_cnt_i = '0;
  logic [1:0]  tbl_act_i = '0;
  logic [3:0]  tbl_id_i = '0;
  logic        irq_o, xfer_o, overrun_o;
  logic [3:0]  irq_idx_o, irq_id_o, xfer_id_o;

  always #2 clk_i = ~clk_i;

  icount_preempt_sched dut (.*);

  int  cyc = 0;
  int  checks = 0, errors = 0, seen = 0;
  bit  finished = 0;
  ev_t q[$];
  ev_t e;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every pulse
  always @(negedge clk_i) begin
    if (rst_ni && (irq_o || xfer_o)) begin
      seen++;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected pulse: actual irq=%0b xfer=%0b idx=%0d cyc=%0d expected none",
                 irq_o, xfer_o, irq_idx_o, cyc);
      end else begin
        e = q.pop_front();
        if (irq_o !== !e.xfer || xfer_o !== e.xfer || cyc != e.cyc ||
            (!e.xfer && irq_idx_o != 4'(e.idx)) ||
            ((e.xfer ? xfer_id_o : irq_id_o) != 4'(e.id))) begin
          errors++;
          $display("FAIL %s pulse: actual xfer=%0b idx=%0d id=%0d cyc=%0d expected xfer=%0b idx=%0d id=%0d cyc=%0d",
                   e.req, xfer_o, irq_idx_o, xfer_o ? xfer_id_o : irq_id_o, cyc,
                   e.xfer, e.idx, e.id, e.cyc);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(int a, int c, int act, int id);
    tbl_we_i = 1'b1; tbl_addr_i = 4'(a); tbl_cnt_i = 32'(c);
    tbl_act_i = 2'(act); tbl_id_i = 4'(id);
    tick(1);
    tbl_we_i = 1'b0;
  endtask

  task automatic do_sync(output int c);
    sync_i = 1'b1; c = cyc;
    tick(1);
    sync_i = 1'b0;
  endtask

  task automatic expect_ev(int c, bit x, int idx, int id, string req);
    ev_t n;
    n.cyc = c; n.xfer = x; n.idx = idx; n.id = id; n.req = req;
    q.push_back(n);
  endtask

  task automatic drained(string req);
    check(q.size() == 0, req, "pending expected pulses", q.size(), 0);
  endtask

  task automatic load_a();
    wr(0, 3, 0, 5); wr(1, 4, 1, 9); wr(2, 10, 0, 2); wr(3, 0, 2, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c, s, s0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    check(irq_o == 0, "R1", "irq_o", irq_o, 0);
    check(xfer_o == 0, "R1", "xfer_o", xfer_o, 0);
    check(overrun_o == 0, "R1", "overrun_o", overrun_o, 0);
    check(irq_idx_o == 0 && irq_id_o == 0, "R1", "irq idx/id", irq_idx_o, 0);
    check(xfer_id_o == 0, "R1", "xfer_id_o", xfer_id_o, 0);
    retire_i = 1'b1; enable_i = 1'b1;
    tick(30);
    check(seen == 0, "R1", "pulses from empty table", seen, 0);

    // R2 R3 R5: basic round
    enable_i = 1'b0; tick(1);
    load_a();
    enable_i = 1'b1;
    do_sync(c);
    expect_ev(c + 5, 0, 0, 5, "R2");
    expect_ev(c + 6, 1, 1, 9, "R3");
    expect_ev(c + 12, 0, 2, 2, "R5");
    tick(40);
    drained("R5");

    // R11: sync while parked, then an early sync mid-round
    do_sync(c);
    expect_ev(c + 5, 0, 0, 5, "R11");
    expect_ev(c + 6, 1, 1, 9, "R11");
    tick(6);
    do_sync(s);
    check(s == c + 7, "R11", "resync cycle", s, c + 7);
    expect_ev(s + 5, 0, 0, 5, "R11");
    expect_ev(s + 6, 1, 1, 9, "R11");
    expect_ev(s + 12, 0, 2, 2, "R11");
    tick(40);
    drained("R11");

    // R6: retire in the sync cycle is not counted
    do_sync(c);
    retire_i = 1'b0;
    tick(5);
    retire_i = 1'b1;
    expect_ev(c + 10, 0, 0, 5, "R6");
    expect_ev(c + 11, 1, 1, 9, "R6");
    expect_ev(c + 17, 0, 2, 2, "R6");
    tick(40);
    drained("R6");

    // R9: disabled block is quiet and ignores sync
    enable_i = 1'b0;
    s0 = seen;
    tick(5);
    do_sync(c);
    tick(10);
    check(seen == s0, "R9", "pulses while disabled", seen - s0, 0);
    enable_i = 1'b1; c = cyc;
    expect_ev(c + 4, 0, 0, 5, "R9");
    expect_ev(c + 5, 1, 1, 9, "R9");
    expect_ev(c + 11, 0, 2, 2, "R9");
    tick(30);
    drained("R9");

    // R8: write while enabled is dropped
    wr(0, 1, 0, 7);
    do_sync(c);
    expect_ev(c + 5, 0, 0, 5, "R8");
    expect_ev(c + 6, 1, 1, 9, "R8");
    expect_ev(c + 12, 0, 2, 2, "R8");
    tick(30);
    drained("R8");

    // R7: duplicate count gets skipped and flags overrun
    enable_i = 1'b0; tick(1);
    wr(0, 2, 0, 1); wr(1, 2, 1, 3); wr(2, 6, 1, 4); wr(3, 0, 3, 0);
    check(overrun_o == 0, "R7", "overrun before", overrun_o, 0);
    enable_i = 1'b1;
    do_sync(c);
    expect_ev(c + 4, 0, 0, 1, "R7");
    expect_ev(c + 8, 1, 2, 4, "R7");
    tick(3);
    check(overrun_o == 0, "R7", "overrun at first match", overrun_o, 0);
    tick(1);
    check(overrun_o == 1, "R7", "overrun after skip", overrun_o, 1);
    tick(30);
    drained("R7");
    do_sync(c);
    expect_ev(c + 4, 0, 0, 1, "R7");
    expect_ev(c + 8, 1, 2, 4, "R7");
    tick(1);
    check(overrun_o == 1, "R7", "overrun sticky over sync", overrun_o, 1);
    tick(30);
    drained("R7");

    // R10: full table without marker, then restart
    enable_i = 1'b0; tick(1);
    for (int i = 0; i < 16; i++) wr(i, i, i % 2, 15 - i);
    enable_i = 1'b1;
    for (int r = 0; r < 2; r++) begin
      do_sync(c);
      for (int i = 0; i < 16; i++) expect_ev(c + 2 + i, bit'(i % 2), i, 15 - i, "R10");
      tick(40);
      drained("R10");
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule